// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Monitor

This block compares the divided reference pulse train with the divided oscillator feedback pulse train for one synthesizer channel. It drives pump-up and pump-down controls and an output enable for an external charge pump. A sequential comparator reacts to rising edges of both inputs, so it steers on frequency error as well as on phase error across a full two-cycle detection window. A fixed reset hold keeps both controls high together for a few clock cycles at the end of every comparison. This removes the dead zone: even a zero phase error produces a short pulse on both controls.

Three settings shape the outputs. The first swaps the up and down controls to suit the tuning slope of the oscillator. The second forces the pump outputs off. The third is a power-down request that takes effect only at a moment when neither pump control is active, so the loop is not kicked as it shuts down. A lock monitor counts back-to-back comparisons whose one-sided error width is small and then raises a lock flag. The flag is high while locked and drops briefly during each comparison pulse.

The comparator state machine has four states. `CMP_IDLE` waits for edges. `CMP_UP` is entered on a reference edge alone and `CMP_DN` on a feedback edge alone. `CMP_HOLD` is entered from `CMP_IDLE` on two simultaneous edges, from `CMP_UP` on a feedback edge, and from `CMP_DN` on a reference edge; it returns to `CMP_IDLE` after `RST_DLY` cycles. The power state machine has two states. `PWR_RUN` moves to `PWR_OFF` when a request is present and both raw controls are low. `PWR_OFF` returns to `PWR_RUN` as soon as the request is withdrawn.

Top module: `pfd_lock`

## Requirements
- R1: The reference and feedback inputs are sampled on the rising clock edge and only their 0-to-1 transitions count. When the reference edge comes d>0 cycles before the feedback edge and polarity is positive, `cp_up` is high for d+RST_DLY cycles and `cp_dn` for RST_DLY cycles (RST_DLY defaults to 2).
- R2: When the feedback edge comes d>0 cycles before the reference edge and polarity is positive, `cp_dn` is high for d+RST_DLY cycles and `cp_up` for RST_DLY cycles.
- R3: Simultaneous edges give pulses of exactly RST_DLY cycles on both controls, and the controls always overlap before they fall together. There is no dead zone.
- R4: Further reference edges while only the up control is active keep it active alone. For example, references at cycles 0 and 3 with feedback at cycle 6 give an up width of 6+RST_DLY and a down width of RST_DLY.
- R5: With `pol_pos`=1 the raw up request drives `cp_up`. With `pol_pos`=0 the two controls are swapped.
- R6: While `force_hiz` is 1, `cp_oe` is 0 and both `cp_up` and `cp_dn` stay 0 whatever the phase error.
- R7: A power-down request does not disable the outputs while a comparison pulse is active. `cp_oe` goes to 0 at the first clock edge where both raw controls are low, and the controls stay 0 afterwards.
- R8: When `pd_req` is withdrawn, `cp_oe` returns to 1 one clock edge later (unless `force_hiz` is 1).
- R9: The error width of a comparison is the number of cycles in which exactly one raw control is high. After LOCK_CNT back-to-back comparisons (default 4) with error width <= ERR_THR (default 3, boundary included), `lock_out` is 1 whenever no control is active and 0 during each pulse.
- R10: A comparison with error width greater than ERR_THR clears the lock indication at its end.
- R11: After reset, `cp_up`, `cp_dn` and `lock_out` are 0 and `cp_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided reference pulse |
| fb_in | input | 1 | Divided oscillator feedback pulse |
| pol_pos | input | 1 | 1: oscillator frequency rises with tuning voltage; 0: swap controls |
| force_hiz | input | 1 | 1: hold the pump outputs off |
| pd_req | input | 1 | Synchronous power-down request |
| cp_up | output | 1 | Pump-up control |
| cp_dn | output | 1 | Pump-down control |
| cp_oe | output | 1 | Pump output enable (0 = high impedance) |
| lock_out | output | 1 | Lock indication, high with brief low pulses when locked |

## Verification
Reference-leading and feedback-leading pairs at a known offset show whether the pulse widths scale with the phase error and land on the correct control. Simultaneous edges show that the dead-zone-free overlap is exactly the reset hold. A double reference with a late feedback separates true frequency steering from a phase-only comparator. Repeating these pairs with polarity cleared, with the forced-off control set, and with a power-down request raised in the middle of a pulse tells the output gating apart from the comparator. Runs of comparisons at the threshold error width and one cycle beyond it pin down the lock count and the clear condition.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
    typedef enum logic [1:0] {
        CMP_IDLE,
        CMP_UP,
        CMP_DN,
        CMP_HOLD
    } cmp_state_t;

    typedef enum logic {
        PWR_RUN,
        PWR_OFF
    } pwr_state_t;
endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_in;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_cmp_fsm.sv
module pfd_cmp_fsm
    import pfd_lock_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic raw_up,
    output logic raw_dn,
    output logic cmp_done
);
    localparam int HW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_DLY - 1);

    cmp_state_t state_q, state_d;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMP_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CMP_HOLD) hold_q <= hold_q + HW'(1);
            else                     hold_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_IDLE: begin
                if (ref_rise && fb_rise) state_d = CMP_HOLD;
                else if (ref_rise)       state_d = CMP_UP;
                else if (fb_rise)        state_d = CMP_DN;
            end
            CMP_UP:   if (fb_rise)  state_d = CMP_HOLD;
            CMP_DN:   if (ref_rise) state_d = CMP_HOLD;
            CMP_HOLD: if (hold_q == HOLD_LAST) state_d = CMP_IDLE;
            default:  state_d = CMP_IDLE;
        endcase
    end

    always_comb begin
        raw_up   = 1'b0;
        raw_dn   = 1'b0;
        cmp_done = 1'b0;
        unique case (state_q)
            CMP_IDLE: ;
            CMP_UP:   raw_up = 1'b1;
            CMP_DN:   raw_dn = 1'b1;
            CMP_HOLD: begin
                raw_up   = 1'b1;
                raw_dn   = 1'b1;
                cmp_done = (hold_q == HOLD_LAST);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pfd_pwr_ctl.sv
module pfd_pwr_ctl
    import pfd_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic raw_up,
    input  logic raw_dn,
    output logic pd_active
);
    pwr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: if (pd_req && !raw_up && !raw_dn) state_d = PWR_OFF;
            PWR_OFF: if (!pd_req) state_d = PWR_RUN;
            default: state_d = PWR_RUN;
        endcase
    end

    always_comb begin
        pd_active = (state_q == PWR_OFF);
    end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int ERR_THR  = 3,
    parameter int LOCK_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_up,
    input  logic raw_dn,
    input  logic cmp_done,
    output logic lock_out
);
    localparam int EW = $clog2(ERR_THR + 2);
    localparam int GW = $clog2(LOCK_CNT + 1);
    localparam logic [EW-1:0] ERR_SAT = EW'(ERR_THR + 1);
    localparam logic [EW-1:0] ERR_LIM = EW'(ERR_THR);
    localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_CNT);

    logic [EW-1:0] err_q;
    logic [GW-1:0] good_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= '0;
            good_q <= '0;
        end else if (cmp_done) begin
            err_q <= '0;
            if (err_q <= ERR_LIM) begin
                if (good_q != GOOD_MAX) good_q <= good_q + GW'(1);
            end else begin
                good_q <= '0;
            end
        end else if ((raw_up ^ raw_dn) && (err_q != ERR_SAT)) begin
            err_q <= err_q + EW'(1);
        end
    end

    assign lock_out = (good_q == GOOD_MAX) & ~raw_up & ~raw_dn;
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
    parameter int RST_DLY  = 2,
    parameter int ERR_THR  = 3,
    parameter int LOCK_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pol_pos,
    input  logic force_hiz,
    input  logic pd_req,
    output logic cp_up,
    output logic cp_dn,
    output logic cp_oe,
    output logic lock_out
);
    logic [1:0] rise;
    logic       raw_up, raw_dn, cmp_done, pd_active;
    logic       dir_up, dir_dn;

    pfd_rise_det #(.WIDTH(2)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({fb_in, ref_in}),
        .rise   (rise)
    );

    pfd_cmp_fsm #(.RST_DLY(RST_DLY)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .raw_up   (raw_up),
        .raw_dn   (raw_dn),
        .cmp_done (cmp_done)
    );

    pfd_pwr_ctl u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .raw_up    (raw_up),
        .raw_dn    (raw_dn),
        .pd_active (pd_active)
    );

    pfd_lock_mon #(.ERR_THR(ERR_THR), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_up   (raw_up),
        .raw_dn   (raw_dn),
        .cmp_done (cmp_done),
        .lock_out (lock_out)
    );

    always_comb begin
        dir_up = pol_pos ? raw_up : raw_dn;
        dir_dn = pol_pos ? raw_dn : raw_up;
        cp_oe  = ~force_hiz & ~pd_active;
        cp_up  = cp_oe & dir_up;
        cp_dn  = cp_oe & dir_dn;
    end
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic force_hiz,
    input logic pd_req,
    input logic cp_up,
    input logic cp_dn,
    input logic cp_oe,
    input logic raw_up,
    input logic raw_dn
);
    AST_HIZ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        force_hiz |-> (!cp_oe && !cp_up && !cp_dn)); // R6

    AST_PD_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cp_oe) && !force_hiz && !$past(force_hiz)) |-> $past(!cp_up && !cp_dn)); // R7

    AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_oe && !pd_req && !force_hiz) |=> (cp_oe || force_hiz)); // R8

    AST_UP_FALL_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_up) |-> ($past(raw_dn) && !raw_dn)); // R3

    AST_DN_FALL_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_dn) |-> ($past(raw_up) && !raw_up)); // R3
endmodule

bind pfd_lock pfd_lock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_hiz (force_hiz),
    .pd_req    (pd_req),
    .cp_up     (cp_up),
    .cp_dn     (cp_dn),
    .cp_oe     (cp_oe),
    .raw_up    (raw_up),
    .raw_dn    (raw_dn)
);

// File: tb/pfd_lock_test.sv
module pfd_lock_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, pol_pos = 1'b1, force_hiz = 1'b0, pd_req = 1'b0;
    logic cp_up, cp_dn, cp_oe, lock_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfd_lock #(.RST_DLY(2), .ERR_THR(3), .LOCK_CNT(4)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pol_pos(pol_pos), .force_hiz(force_hiz), .pd_req(pd_req),
        .cp_up(cp_up), .cp_dn(cp_dn), .cp_oe(cp_oe), .lock_out(lock_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives one comparison; indices are negedge cycles, -1 means none.
    task automatic run_cmp(input int ref_a, input int ref_b, input int fb_a,
                           output int up_w, output int dn_w, output int lk_lo);
        up_w = 0; dn_w = 0; lk_lo = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (cp_up) up_w++;
            if (cp_dn) dn_w++;
            if (!lock_out) lk_lo++;
            ref_in = (c == ref_a) || (c == ref_b);
            fb_in  = (c == fb_a);
        end
        ref_in = 1'b0; fb_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 up", int'(cp_up), 0);
        check("R11 dn", int'(cp_dn), 0);
        check("R11 oe", int'(cp_oe), 1);
        check("R11 lock", int'(lock_out), 0);
    endtask

    task automatic t_ref_lead();
        int u, d, l;
        run_cmp(1, -1, 4, u, d, l);
        check("R1 up width", u, 5);
        check("R1 dn width", d, 2);
    endtask

    task automatic t_fb_lead();
        int u, d, l;
        run_cmp(4, -1, 1, u, d, l);
        check("R2 dn width", d, 5);
        check("R2 up width", u, 2);
    endtask

    task automatic t_zero_err();
        int u, d, l;
        run_cmp(2, -1, 2, u, d, l);
        check("R3 up width", u, 2);
        check("R3 dn width", d, 2);
    endtask

    task automatic t_freq();
        int u, d, l;
        run_cmp(1, 4, 7, u, d, l);
        check("R4 up width", u, 8);
        check("R4 dn width", d, 2);
    endtask

    task automatic t_polarity();
        int u, d, l;
        pol_pos = 1'b0;
        run_cmp(1, -1, 4, u, d, l);
        check("R5 swapped dn", d, 5);
        check("R5 swapped up", u, 2);
        pol_pos = 1'b1;
    endtask

    task automatic t_hiz();
        int u, d, l;
        force_hiz = 1'b1;
        @(negedge clk);
        check("R6 oe", int'(cp_oe), 0);
        run_cmp(1, -1, 5, u, d, l);
        check("R6 up", u, 0);
        check("R6 dn", d, 0);
        force_hiz = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_pwrdn();
        int u, d, l;
        @(negedge clk); ref_in = 1'b1;
        @(negedge clk); ref_in = 1'b0; pd_req = 1'b1;
        @(negedge clk);
        check("R7 oe kept during pulse", int'(cp_oe), 1);
        check("R7 up kept during pulse", int'(cp_up), 1);
        fb_in = 1'b1;
        @(negedge clk); fb_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 oe off at idle", int'(cp_oe), 0);
        run_cmp(1, -1, 4, u, d, l);
        check("R7 up off", u, 0);
        check("R7 dn off", d, 0);
        pd_req = 1'b0;
        @(negedge clk);
        check("R8 oe restored", int'(cp_oe), 1);
    endtask

    task automatic t_lock();
        int u, d, l;
        run_cmp(1, -1, 7, u, d, l);
        for (int k = 0; k < 3; k++) run_cmp(1, -1, 4, u, d, l);
        check("R9 not yet locked", int'(lock_out), 0);
        run_cmp(1, -1, 4, u, d, l);
        check("R9 locked at threshold", int'(lock_out), 1);
        run_cmp(2, -1, 2, u, d, l);
        check("R9 low glitch width", l, 2);
        check("R9 still locked", int'(lock_out), 1);
        run_cmp(1, -1, 5, u, d, l);
        check("R10 lock cleared", int'(lock_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ref_lead();
        t_fb_lead();
        t_zero_err();
        t_freq();
        t_polarity();
        t_hiz();
        t_pwrdn();
        t_lock();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule